// File: doc/BRIEF.md
# Audio Sample Stream Fetch and Playout Engine

This block is a memory-reading engine that plays a buffer of audio samples. Software programs a 24-bit byte address where the buffer starts and a 24-bit byte address one past its last byte, picks a sample format and a rate, and sets the run bit. The engine then reads 16-bit memory words in ascending address order through a one-outstanding request/valid handshake. It holds them in a small prefetch queue. On every tick of a rate divider it presents one left/right frame on the output port.

Samples may be 8 or 16 bits wide and mono or stereo. The lowest rate code keeps the timing of the slowest rate but outputs silence. When the last word of the buffer has been requested, the engine raises a one-cycle interrupt. In repeat mode it reloads the buffer bounds from the host registers and keeps streaming without a gap. Otherwise it plays out what it has fetched and then drops the run bit. A sticky flag records any tick that found the queue short of a frame.

Top module: `audio_dma_player`

## Requirements
- R1: After reset every register reads 0, and `mem_req`, `out_valid`, `irq` and `underrun` are low.
- R2: Register offsets are as follows. 0 is control: bit 0 = run, bit 1 = repeat. 1 is mode: bit 7 = mono (1) or stereo (0), bit 6 = 16-bit (1) or 8-bit (0), bits [1:0] = rate code. 2/3/4 hold the start address bytes [23:16]/[15:8]/[7:0]. 5/6/7 hold the end address bytes in the same order. 8/9/10 are the read-only current fetch address in the same byte order, readable while playing. Any other offset reads 0.
- R3: Setting run while idle copies the start and end addresses into the engine. Host address writes made while playing take effect only at the next buffer wrap.
- R4: Memory is read as 16-bit words at even byte addresses starting at the start address and stepping by 2, with at most one read outstanding. The byte at the lower address is in bits [15:8]. A buffer ends with the word whose next address is at or beyond the end address.
- R5: 16-bit mono: each frame takes one word, and left = right = that word.
- R6: 16-bit stereo: each frame takes two words; left is the word at the lower address.
- R7: 8-bit stereo: each frame takes one word; left = {bits [15:8], 8'h00} and right = {bits [7:0], 8'h00}.
- R8: 8-bit mono: each word gives two frames, the upper byte first. Each frame is {byte, 8'h00} on both channels.
- R9: `out_valid` pulses once every DIVn clock cycles for rate code n. Rate code 0 still consumes samples but outputs zero on both channels.
- R10: `irq` pulses for exactly one cycle each time the last word of the buffer is requested.
- R11: Without repeat, after the last word the engine stops fetching, plays every complete frame already fetched, and then clears the run bit.
- R12: With repeat, fetching continues from the start address held in the host registers, with no break in the output.
- R13: Clearing run while playing stops the output at once; a read still in flight is discarded.
- R14: A tick that finds less than a frame queued while fetching is still active outputs a zero frame and sets `underrun`. The flag stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Read request, accepted in the cycle it is high |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| out_valid | output | 1 | Frame strobe |
| out_left | output | 16 | Left sample |
| out_right | output | 16 | Right sample |
| irq | output | 1 | End-of-buffer pulse |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The bench checks the byte order inside a word separately for each of the four formats. A swapped unpack would put the right sample on the left or play the two bytes of an 8-bit mono word backwards. It checks that a single-shot buffer ends with exactly its own frames and one interrupt, so an off-by-one end compare would add or lose a frame. It rewrites the buffer bounds while a repeat loop runs and checks that the loop moves to the new buffer, which fails if the bounds are not reloaded at the wrap. It holds memory back to force starvation, which exposes a design that outputs stale data or lets the flag clear on its own. It also stops playback in mid-stream and checks that no frame follows the stop.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [3:0] {
    REG_CTRL  = 4'd0,
    REG_MODE  = 4'd1,
    REG_STA_H = 4'd2,
    REG_STA_M = 4'd3,
    REG_STA_L = 4'd4,
    REG_END_H = 4'd5,
    REG_END_M = 4'd6,
    REG_END_L = 4'd7,
    REG_CUR_H = 4'd8,
    REG_CUR_M = 4'd9,
    REG_CUR_L = 4'd10
  } reg_sel_e;

  typedef struct packed {
    logic       mono;
    logic       wide;
    logic [1:0] rate;
  } play_mode_t;
endpackage

// File: rtl/adp_regs.sv
module adp_regs
  import adp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              finish,
  output logic              run,
  output logic              rpt,
  output play_mode_t        mode,
  output logic [ADDR_W-1:0] start_host,
  output logic [ADDR_W-1:0] end_host,
  output logic              start_pulse,
  output logic              stop_pulse
);
  logic              run_q, run_d, rpt_q, rpt_d;
  play_mode_t        mode_q, mode_d;
  logic [ADDR_W-1:0] sta_q, sta_d, end_q, end_d;
  logic              ctrl_wr, mode_wr, addr_wr;

  assign ctrl_wr     = wr && (addr == REG_CTRL);
  assign mode_wr     = wr && (addr == REG_MODE);
  assign start_pulse = ctrl_wr && wdata[0] && !run_q;
  assign stop_pulse  = ctrl_wr && !wdata[0] && run_q;

  always_comb begin
    run_d = run_q;
    if (finish)       run_d = 1'b0;
    else if (ctrl_wr) run_d = wdata[0];
    rpt_d  = ctrl_wr ? wdata[1] : rpt_q;
    mode_d = mode_wr ? play_mode_t'({wdata[7], wdata[6], wdata[1:0]}) : mode_q;
  end

  always_comb begin
    sta_d   = sta_q;
    end_d   = end_q;
    addr_wr = 1'b0;
    if (wr) begin
      addr_wr = 1'b1;
      case (addr)
        REG_STA_H: sta_d[23:16] = wdata;
        REG_STA_M: sta_d[15:8]  = wdata;
        REG_STA_L: sta_d[7:0]   = wdata;
        REG_END_H: end_d[23:16] = wdata;
        REG_END_M: end_d[15:8]  = wdata;
        REG_END_L: end_d[7:0]   = wdata;
        default:   addr_wr      = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rpt_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      run_q <= run_d;
      if (ctrl_wr) rpt_q  <= rpt_d;
      if (mode_wr) mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      end_q <= '0;
    end else if (addr_wr) begin
      sta_q <= sta_d;
      end_q <= end_d;
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:  rdata = {6'b0, rpt_q, run_q};
      REG_MODE:  rdata = {mode_q.mono, mode_q.wide, 4'b0, mode_q.rate};
      REG_STA_H: rdata = sta_q[23:16];
      REG_STA_M: rdata = sta_q[15:8];
      REG_STA_L: rdata = sta_q[7:0];
      REG_END_H: rdata = end_q[23:16];
      REG_END_M: rdata = end_q[15:8];
      REG_END_L: rdata = end_q[7:0];
      REG_CUR_H: rdata = cur_addr[23:16];
      REG_CUR_M: rdata = cur_addr[15:8];
      REG_CUR_L: rdata = cur_addr[7:0];
      default:   rdata = 8'h00;
    endcase
  end

  assign run        = run_q;
  assign rpt        = rpt_q;
  assign mode       = mode_q;
  assign start_host = sta_q;
  assign end_host   = end_q;

  AST_FINISH_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !run_q); // R11
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !run_q); // R13
endmodule

// File: rtl/adp_fetch.sv
module adp_fetch
  import adp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rpt,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic [ADDR_W-1:0] start_host,
  input  logic [ADDR_W-1:0] end_host,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              push,
  output logic              fetch_done,
  output logic              fetch_pend,
  output logic              irq
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, lim_q, lim_d, ptr_nx;
  logic              done_q, done_d, pend_q, pend_d, drop_q, drop_d, irq_q, irq_d;
  logic              issue, wrap, ret;

  assign issue  = run && !done_q && !pend_q && (fifo_count < CNT_W'(FIFO_DEPTH));
  assign ptr_nx = ptr_q + ADDR_W'(2);
  assign wrap   = (ptr_nx >= lim_q);
  assign ret    = pend_q && mem_rvalid;

  always_comb begin
    ptr_d  = ptr_q;
    lim_d  = lim_q;
    done_d = done_q;
    irq_d  = 1'b0;
    if (start_pulse) begin
      ptr_d  = start_host;
      lim_d  = end_host;
      done_d = 1'b0;
    end else if (issue) begin
      ptr_d = ptr_nx;
      if (wrap) begin
        irq_d = 1'b1;
        if (rpt) begin
          ptr_d = start_host;
          lim_d = end_host;
        end else begin
          done_d = 1'b1;
        end
      end
    end
  end

  always_comb begin
    pend_d = pend_q;
    drop_d = drop_q;
    if (ret) begin
      pend_d = 1'b0;
      drop_d = 1'b0;
    end
    if (issue) pend_d = 1'b1;
    if (stop_pulse && (issue || (pend_q && !mem_rvalid))) drop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      lim_q  <= lim_d;
      done_q <= done_d;
      pend_q <= pend_d;
      drop_q <= drop_d;
      irq_q  <= irq_d;
    end
  end

  assign mem_req    = issue;
  assign mem_addr   = ptr_q;
  assign cur_addr   = ptr_q;
  assign push       = ret && !drop_q;
  assign fetch_done = done_q;
  assign fetch_pend = pend_q;
  assign irq        = irq_q;

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
endmodule

// File: rtl/adp_fifo.sv
module adp_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic [1:0]       pop_n,
  output logic [CNT_W-1:0] count,
  output logic [WIDTH-1:0] head0,
  output logic [WIDTH-1:0] head1
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q + IDX_W'(pop_n);
    wr_d  = push ? wr_q + IDX_W'(1) : wr_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop_n);
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !flush && (wr_q == IDX_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_we) mem_q[gi] <= wdata;
    end
  end

  assign count = cnt_q;
  assign head0 = mem_q[rd_q];
  assign head1 = mem_q[rd_q + IDX_W'(1)];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_n == 2'd0) |-> (cnt_q < CNT_W'(DEPTH))); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n != 2'd0) |-> (cnt_q >= CNT_W'(pop_n))); // R14
endmodule

// File: rtl/adp_playout.sv
module adp_playout
  import adp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DIV0 = 7990,
  parameter int unsigned DIV1 = 3995,
  parameter int unsigned DIV2 = 1997,
  parameter int unsigned DIV3 = 999,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned DIV_MAX = (DIV0 > DIV1 ? DIV0 : DIV1) > (DIV2 > DIV3 ? DIV2 : DIV3)
                                  ? (DIV0 > DIV1 ? DIV0 : DIV1) : (DIV2 > DIV3 ? DIV2 : DIV3),
  localparam int unsigned DW = $clog2(DIV_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start_pulse,
  input  play_mode_t        mode,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic [WORD_W-1:0] head0,
  input  logic [WORD_W-1:0] head1,
  input  logic              fetch_done,
  input  logic              fetch_pend,
  output logic [1:0]        pop_n,
  output logic              finish,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right,
  output logic              underrun
);
  localparam int unsigned DIV_TAB [4] = '{DIV0, DIV1, DIV2, DIV3};

  logic [DW-1:0]     div_q, div_d, reload;
  logic              tick, pair, frame_ok, take, starve;
  logic              phase_q, phase_d, urun_q, urun_d, vld_q, vld_d;
  logic [WORD_W-1:0] left_q, left_d, right_q, right_d, fl, fr;
  logic [7:0]        byte_sel;

  assign reload = DW'(DIV_TAB[mode.rate] - 1);
  assign tick   = run && (div_q == '0);

  always_comb begin
    div_d = div_q - DW'(1);
    if (!run || div_q == '0) div_d = reload;
  end

  assign pair     = mode.wide && !mode.mono;
  assign frame_ok = fifo_count >= (pair ? CNT_W'(2) : CNT_W'(1));
  assign finish   = run && fetch_done && !fetch_pend && !frame_ok;
  assign take     = tick && frame_ok;
  assign starve   = tick && !frame_ok && !finish;
  assign byte_sel = phase_q ? head0[7:0] : head0[15:8];

  always_comb begin
    pop_n = 2'd0;
    if (take) begin
      if (pair)                                pop_n = 2'd2;
      else if (mode.wide || !mode.mono || phase_q) pop_n = 2'd1;
    end
  end

  always_comb begin
    case ({mode.wide, mode.mono})
      2'b10:   begin fl = head0;               fr = head1;               end
      2'b11:   begin fl = head0;               fr = head0;               end
      2'b00:   begin fl = {head0[15:8], 8'h00}; fr = {head0[7:0], 8'h00}; end
      default: begin fl = {byte_sel, 8'h00};   fr = {byte_sel, 8'h00};   end
    endcase
  end

  always_comb begin
    vld_d   = take || starve;
    left_d  = left_q;
    right_d = right_q;
    if (take || starve) begin
      left_d  = '0;
      right_d = '0;
    end
    if (take && mode.rate != 2'd0) begin
      left_d  = fl;
      right_d = fr;
    end
    phase_d = phase_q;
    if (start_pulse)                             phase_d = 1'b0;
    else if (take && !mode.wide && mode.mono)    phase_d = !phase_q;
    urun_d = urun_q;
    if (start_pulse) urun_d = 1'b0;
    else if (starve) urun_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      urun_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      div_q   <= div_d;
      phase_q <= phase_d;
      urun_q  <= urun_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (vld_d) begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  assign out_valid = vld_q;
  assign out_left  = left_q;
  assign out_right = right_q;
  assign underrun  = urun_q;

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R9
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode.rate == 2'd0 && $past(mode.rate) == 2'd0)
      |-> (out_left == '0 && out_right == '0)); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !start_pulse) |=> underrun); // R14
endmodule

// File: rtl/audio_dma_player.sv
module audio_dma_player
  import adp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DIV0 = 7990,
  parameter int unsigned DIV1 = 3995,
  parameter int unsigned DIV2 = 1997,
  parameter int unsigned DIV3 = 999
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [15:0] mem_rdata,
  output logic        out_valid,
  output logic [15:0] out_left,
  output logic [15:0] out_right,
  output logic        irq,
  output logic        underrun
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              run, rpt, start_pulse, stop_pulse, finish, push;
  logic              fetch_done, fetch_pend;
  play_mode_t        mode;
  logic [ADDR_W-1:0] start_host, end_host, cur_addr;
  logic [CNT_W-1:0]  fifo_count;
  logic [WORD_W-1:0] head0, head1;
  logic [1:0]        pop_n;

  adp_regs u_regs (
    .clk, .rst_n,
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .cur_addr, .finish, .run, .rpt, .mode, .start_host, .end_host,
    .start_pulse, .stop_pulse
  );

  adp_fetch #(.FIFO_DEPTH(FIFO_DEPTH)) u_fetch (
    .clk, .rst_n, .run, .rpt, .start_pulse, .stop_pulse,
    .start_host, .end_host, .fifo_count, .mem_rvalid,
    .mem_req, .mem_addr, .cur_addr, .push, .fetch_done, .fetch_pend, .irq
  );

  adp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk, .rst_n, .flush(start_pulse || stop_pulse || finish),
    .push, .wdata(mem_rdata), .pop_n, .count(fifo_count), .head0, .head1
  );

  adp_playout #(.FIFO_DEPTH(FIFO_DEPTH), .DIV0(DIV0), .DIV1(DIV1),
                .DIV2(DIV2), .DIV3(DIV3)) u_play (
    .clk, .rst_n, .run, .start_pulse, .mode, .fifo_count, .head0, .head1,
    .fetch_done, .fetch_pend, .pop_n, .finish,
    .out_valid, .out_left, .out_right, .underrun
  );
endmodule

// File: tb/audio_dma_player_tb_top.sv
module audio_dma_player_tb_top;
  localparam int D0 = 40, D1 = 24, D2 = 16, D3 = 12;

  logic        clk, rst_n, reg_wr, mem_req, mem_rvalid, out_valid, irq, underrun;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata, out_left, out_right;

  int n_chk = 0, n_fail = 0, nf = 0, nirq = 0, cyc = 0;
  logic [15:0] fl [64];
  logic [15:0] fr [64];
  int          ft [64];
  bit          stall = 0;

  audio_dma_player #(.FIFO_DEPTH(4), .DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) dut_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .out_valid, .out_left, .out_right, .irq, .underrun
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: byte at address a holds a[7:0]
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        automatic logic [23:0] a = mem_addr;
        @(negedge clk);
        while (stall) @(negedge clk);
        mem_rdata  = {a[7:0], a[7:0] + 8'd1};
        mem_rvalid = 1'b1;
      end
    end
  end

  // output monitor and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (out_valid && nf < 64) begin
        fl[nf] = out_left; fr[nf] = out_right; ft[nf] = cyc; nf++;
      end
      if (irq) nirq++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_cur(output logic [23:0] v);
    logic [7:0] b;
    rd(4'd8, b); v[23:16] = b;
    rd(4'd9, b); v[15:8]  = b;
    rd(4'd10, b); v[7:0]  = b;
  endtask

  task automatic setup(input logic [23:0] s, input logic [23:0] e, input logic [7:0] m);
    wr(4'd2, s[23:16]); wr(4'd3, s[15:8]); wr(4'd4, s[7:0]);
    wr(4'd5, e[23:16]); wr(4'd6, e[15:8]); wr(4'd7, e[7:0]);
    wr(4'd1, m);
    nf = 0; nirq = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    c = 8'h01;
    for (int i = 0; i < 4000 && c[0]; i++) rd(4'd0, c);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 4000 && nf < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] c; logic [23:0] cur;
    rd(4'd0, c); chk(c == 8'h00, "R1 ctrl", c, 0);
    rd(4'd1, c); chk(c == 8'h00, "R1 mode", c, 0);
    rd_cur(cur); chk(cur == 24'h0, "R1 current address", cur, 0);
    chk(!mem_req && !out_valid && !irq && !underrun, "R1 outputs idle",
        {mem_req, out_valid, irq, underrun}, 0);
    rd(4'd13, c); chk(c == 8'h00, "R2 unused offset", c, 0);
  endtask

  task automatic t_wide_mono();
    logic [7:0] c; logic [23:0] cur;
    setup(24'h000100, 24'h000108, 8'hC3);
    rd(4'd1, c); chk(c == 8'hC3, "R2 mode readback", c, 8'hC3);
    wr(4'd0, 8'h01);
    wait_idle();
    chk(nf == 4, "R11 frame count single shot", nf, 4);
    chk(fl[0] == 16'h0001 && fr[0] == 16'h0001, "R5 frame0", {fl[0], fr[0]}, 32'h00010001);
    chk(fl[3] == 16'h0607 && fr[3] == 16'h0607, "R5 frame3 order R4", {fl[3], fr[3]}, 32'h06070607);
    chk(ft[1] - ft[0] == D3, "R9 rate code 3 period", ft[1] - ft[0], D3);
    chk(nirq == 1, "R10 one irq per buffer", nirq, 1);
    rd(4'd0, c); chk(c[0] == 1'b0, "R11 run cleared", c, 0);
    rd_cur(cur); chk(cur == 24'h000108, "R2 current address at end", cur, 24'h108);
  endtask

  task automatic t_byte_stereo();
    setup(24'h002010, 24'h002014, 8'h01);
    wr(4'd0, 8'h01);
    wait_idle();
    chk(nf == 2, "R7 frame count", nf, 2);
    chk(fl[0] == 16'h1000 && fr[0] == 16'h1100, "R7 frame0 left upper", {fl[0], fr[0]}, 32'h10001100);
    chk(fl[1] == 16'h1200 && fr[1] == 16'h1300, "R7 frame1", {fl[1], fr[1]}, 32'h12001300);
    chk(ft[1] - ft[0] == D1, "R9 rate code 1 period", ft[1] - ft[0], D1);
  endtask

  task automatic t_byte_mono();
    setup(24'h003020, 24'h003022, 8'h82);
    wr(4'd0, 8'h01);
    wait_idle();
    chk(nf == 2, "R8 two frames per word", nf, 2);
    chk(fl[0] == 16'h2000 && fr[0] == 16'h2000, "R8 upper byte first", {fl[0], fr[0]}, 32'h20002000);
    chk(fl[1] == 16'h2100 && fr[1] == 16'h2100, "R8 lower byte second", {fl[1], fr[1]}, 32'h21002100);
    chk(ft[1] - ft[0] == D2, "R9 rate code 2 period", ft[1] - ft[0], D2);
  endtask

  task automatic t_wide_stereo();
    setup(24'h004040, 24'h004048, 8'h43);
    wr(4'd0, 8'h01);
    wait_idle();
    chk(nf == 2, "R6 frame count", nf, 2);
    chk(fl[0] == 16'h4041 && fr[0] == 16'h4243, "R6 frame0 left lower address", {fl[0], fr[0]}, 32'h40414243);
    chk(fl[1] == 16'h4445 && fr[1] == 16'h4647, "R6 frame1", {fl[1], fr[1]}, 32'h44454647);
  endtask

  task automatic t_mute();
    setup(24'h000700, 24'h000704, 8'hC0);
    wr(4'd0, 8'h01);
    wait_idle();
    chk(nf == 2, "R9 mute still consumes", nf, 2);
    chk(fl[0] == 0 && fr[0] == 0 && fl[1] == 0 && fr[1] == 0, "R9 mute zero",
        {fl[0], fr[1]}, 0);
    chk(ft[1] - ft[0] == D0, "R9 rate code 0 period", ft[1] - ft[0], D0);
    chk(nirq == 1, "R10 irq in mute", nirq, 1);
  endtask

  task automatic t_repeat_stop();
    logic [7:0] c; logic [23:0] cur; int snap; bit ok;
    setup(24'h000500, 24'h000504, 8'hC3);
    wr(4'd0, 8'h03);
    wait_frames(6);
    ok = 1;
    for (int i = 0; i < 6; i++) if (fl[i] != ((i % 2) ? 16'h0203 : 16'h0001)) ok = 0;
    chk(ok, "R12 gapless loop data", fl[5], 16'h0203);
    chk(ft[5] - ft[0] == 5 * D3, "R12 no gap at wrap", ft[5] - ft[0], 5 * D3);
    chk(nirq >= 2, "R10 irq each wrap", nirq, 2);
    rd(4'd0, c); chk(c == 8'h03, "R12 run held in repeat", c, 8'h03);
    rd_cur(cur); chk(cur >= 24'h000500 && cur <= 24'h000504, "R2 current address while playing", cur, 24'h500);
    wr(4'd6, 8'h06); wr(4'd7, 8'h12); wr(4'd3, 8'h06); wr(4'd4, 8'h10);
    snap = nf;
    wait_frames(snap + 12);
    ok = 1;
    for (int i = nf - 4; i < nf; i++) if (fl[i] != 16'h1011) ok = 0;
    chk(ok, "R3 new bounds applied at wrap", fl[nf - 1], 16'h1011);
    wr(4'd0, 8'h00);
    repeat (2) @(negedge clk);
    snap = nf;
    repeat (5 * D3) @(negedge clk);
    chk(nf == snap, "R13 no frames after stop", nf, snap);
    rd(4'd0, c); chk(c[0] == 1'b0, "R13 run cleared by host", c, 0);
  endtask

  task automatic t_underrun();
    bit seen;
    stall = 1;
    setup(24'h000800, 24'h000808, 8'hC3);
    wr(4'd0, 8'h01);
    wait_frames(3);
    chk(fl[0] == 0 && fl[2] == 0, "R14 zero frame on starve", fl[2], 0);
    chk(underrun == 1'b1, "R14 flag set", underrun, 1);
    stall = 0;
    wait_idle();
    seen = 0;
    for (int i = 0; i < nf; i++) if (fl[i] == 16'h0001) seen = 1;
    chk(seen, "R14 stream resumes", seen, 1);
    chk(fl[nf - 1] == 16'h0607, "R14 last frame after resume", fl[nf - 1], 16'h0607);
    chk(underrun == 1'b1, "R14 flag sticky", underrun, 1);
    setup(24'h000900, 24'h000902, 8'hC3);
    wr(4'd0, 8'h01);
    chk(underrun == 1'b0, "R14 cleared on start", underrun, 0);
    wait_idle();
    chk(nf == 1 && fl[0] == 16'h0001, "R3 one-word buffer", fl[0], 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide_mono();
    t_byte_stereo();
    t_byte_mono();
    t_wide_stereo();
    t_mute();
    t_repeat_stop();
    t_underrun();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule